// File: doc/BRIEF.md
# Accumulator Logic, Shift and Flag Unit

This block is the single-cycle execution core of a small accumulator machine. It holds a 16-bit accumulator, a 16-bit extension register that joins the accumulator for a double-length rotate, a carry flag, zero and sign status flags, and an interrupt-enable flip-flop. Each cycle in which `op_valid` is high, the unit takes a 5-bit operation code and a 16-bit second operand. On the next rising clock edge it updates its state.

The operations cover several groups:
- clearing and inverting the accumulator;
- bitwise AND, OR and XOR with the operand;
- direct control of the carry and interrupt-enable bits;
- logical and arithmetic shifts, and a rotate through the extension register;
- increment and decrement;
- compare and test, which change only the status flags.

Fetch, decode and memory access sit outside the block. All state is visible on the output ports.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the unit holds accumulator 0, extension 0, carry 0, interrupt enable 0, zero flag 1 and sign flag 0.
- R2: Code 0x00 loads all zeros into the accumulator. Code 0x01 replaces the accumulator with its bitwise inverse.
- R3: Code 0x02 ANDs the operand into the accumulator bit by bit. Code 0x03 ORs it in. Code 0x04 XORs it in.
- R4: Code 0x05 clears carry, code 0x06 sets carry and code 0x07 inverts carry. These codes leave the accumulator, the extension and the status flags unchanged.
- R5: Code 0x08 sets the interrupt-enable bit and code 0x09 clears it. No other code changes that bit.
- R6: Code 0x0A shifts the accumulator left, with 0 entering bit 0 and the old bit 15 going to carry. Code 0x0B shifts it right, with 0 entering bit 15 and the old bit 0 going to carry.
- R7: Code 0x0C shifts the accumulator right one place and keeps the old bit 15 in bit 15. Carry is unchanged.
- R8: Code 0x0D rotates the 32-bit value {accumulator, extension} right by one. Extension bit 0 enters accumulator bit 15, and accumulator bit 0 enters extension bit 15. Carry is unchanged.
- R9: Code 0x0E adds one to the accumulator, and carry receives the carry out (set only when 0xFFFF wraps to 0). Code 0x0F subtracts one, and carry receives the borrow (set only when 0 wraps to 0xFFFF).
- R10: Code 0x10 sets zero and sign from accumulator minus operand. Code 0x11 sets them from accumulator AND operand. Both codes leave the accumulator, the extension and carry unchanged.
- R11: After any operation that writes the accumulator, zero is 1 exactly when the new accumulator is 0, and sign equals its bit 15. The extension register changes only on code 0x0D.
- R12: Codes 0x12 to 0x1F, and any cycle with `op_valid` low, leave every register and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| operand | input | 16 | Second operand |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 16 | Accumulator extension register |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero status flag |
| sign_q | output | 1 | Sign status flag |
| irq_en_q | output | 1 | Interrupt-enable flip-flop |

## Verification
Every result, whether accumulator, extension, carry, status flag or interrupt enable, appears on the outputs one rising edge after the operation is presented. No result takes longer. The bench drives each operation on a falling edge and samples all six outputs shortly after the next rising edge. At that same point it advances its own model, so every comparison lands in the single cycle where the new state first becomes visible. The idle and unused-code vectors are checked in the same way, so an unwanted change shows up at the first edge where it could occur.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_CLR   = 5'h00,
    OP_INV   = 5'h01,
    OP_AND   = 5'h02,
    OP_OR    = 5'h03,
    OP_XOR   = 5'h04,
    OP_CCLR  = 5'h05,
    OP_CSET  = 5'h06,
    OP_CINV  = 5'h07,
    OP_IEN   = 5'h08,
    OP_IDIS  = 5'h09,
    OP_SHL   = 5'h0A,
    OP_SHR   = 5'h0B,
    OP_ASR   = 5'h0C,
    OP_ROTX  = 5'h0D,
    OP_INC   = 5'h0E,
    OP_DEC   = 5'h0F,
    OP_CMP   = 5'h10,
    OP_TST   = 5'h11
  } acc_op_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic [W-1:0]     operand,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     ext,
  input  logic             carry,
  output logic [W-1:0]     nxt_acc,
  output logic [W-1:0]     nxt_ext,
  output logic             nxt_carry,
  output logic             nxt_ie,
  output logic [W-1:0]     flag_src,
  output logic             acc_we,
  output logic             ext_we,
  output logic             carry_we,
  output logic             ie_we,
  output logic             flag_we,
  output logic             op_known
);
  localparam int WX = W + 1;

  function automatic logic [WX-1:0] f_inc(input logic [W-1:0] a);
    return {1'b0, a} + WX'(1);
  endfunction

  function automatic logic [WX-1:0] f_dec(input logic [W-1:0] a);
    return {1'b0, a} - WX'(1);
  endfunction

  function automatic logic [2*W-1:0] f_rot(input logic [W-1:0] hi, input logic [W-1:0] lo);
    return {lo[0], hi, lo[W-1:1]};
  endfunction

  logic [WX-1:0]  inc_r, dec_r;
  logic [2*W-1:0] rot_r;
  acc_op_e        op;

  assign inc_r = f_inc(acc);
  assign dec_r = f_dec(acc);
  assign rot_r = f_rot(acc, ext);
  assign op    = acc_op_e'(op_code);

  always_comb begin
    nxt_acc   = acc;
    nxt_ext   = ext;
    nxt_carry = carry;
    nxt_ie    = 1'b0;
    flag_src  = acc;
    acc_we    = 1'b0;
    ext_we    = 1'b0;
    carry_we  = 1'b0;
    ie_we     = 1'b0;
    flag_we   = 1'b0;
    op_known  = 1'b1;
    case (op)
      OP_CLR:  begin nxt_acc = '0;            acc_we = 1'b1; end
      OP_INV:  begin nxt_acc = ~acc;          acc_we = 1'b1; end
      OP_AND:  begin nxt_acc = acc & operand; acc_we = 1'b1; end
      OP_OR:   begin nxt_acc = acc | operand; acc_we = 1'b1; end
      OP_XOR:  begin nxt_acc = acc ^ operand; acc_we = 1'b1; end
      OP_CCLR: begin nxt_carry = 1'b0;   carry_we = 1'b1; end
      OP_CSET: begin nxt_carry = 1'b1;   carry_we = 1'b1; end
      OP_CINV: begin nxt_carry = ~carry; carry_we = 1'b1; end
      OP_IEN:  begin nxt_ie = 1'b1; ie_we = 1'b1; end
      OP_IDIS: begin nxt_ie = 1'b0; ie_we = 1'b1; end
      OP_SHL: begin
        nxt_acc = {acc[W-2:0], 1'b0}; nxt_carry = acc[W-1];
        acc_we = 1'b1; carry_we = 1'b1;
      end
      OP_SHR: begin
        nxt_acc = {1'b0, acc[W-1:1]}; nxt_carry = acc[0];
        acc_we = 1'b1; carry_we = 1'b1;
      end
      OP_ASR:  begin nxt_acc = {acc[W-1], acc[W-1:1]}; acc_we = 1'b1; end
      OP_ROTX: begin
        nxt_acc = rot_r[2*W-1:W]; nxt_ext = rot_r[W-1:0];
        acc_we = 1'b1; ext_we = 1'b1;
      end
      OP_INC: begin
        nxt_acc = inc_r[W-1:0]; nxt_carry = inc_r[W];
        acc_we = 1'b1; carry_we = 1'b1;
      end
      OP_DEC: begin
        nxt_acc = dec_r[W-1:0]; nxt_carry = dec_r[W];
        acc_we = 1'b1; carry_we = 1'b1;
      end
      OP_CMP: begin flag_src = acc - operand; flag_we = 1'b1; end
      OP_TST: begin flag_src = acc & operand; flag_we = 1'b1; end
      default: op_known = 1'b0;
    endcase
    if (acc_we) flag_src = nxt_acc;
    flag_we = flag_we | acc_we;
    if (!op_valid) begin
      acc_we = 1'b0; ext_we = 1'b0; carry_we = 1'b0;
      ie_we  = 1'b0; flag_we = 1'b0;
    end
  end
endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt_acc,
  input  logic [W-1:0] nxt_ext,
  input  logic         nxt_carry,
  input  logic         nxt_ie,
  input  logic [W-1:0] flag_src,
  input  logic         acc_we,
  input  logic         ext_we,
  input  logic         carry_we,
  input  logic         ie_we,
  input  logic         flag_we,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] ext_q,
  output logic         carry_q,
  output logic         zero_q,
  output logic         sign_q,
  output logic         ie_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ext_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b1;
      sign_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (acc_we)   acc_q   <= nxt_acc;
      if (ext_we)   ext_q   <= nxt_ext;
      if (carry_we) carry_q <= nxt_carry;
      if (ie_we)    ie_q    <= nxt_ie;
      if (flag_we) begin
        zero_q <= (flag_src == '0);
        sign_q <= flag_src[W-1];
      end
    end
  end

  // R11: flags follow the accumulator after every accumulator write
  a_r11_flags_follow_acc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> (zero_q == (acc_q == '0)) && (sign_q == acc_q[W-1]));

  // R5: interrupt enable moves only when its own operations ask for it
  a_r5_ie_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_we |=> $stable(ie_q));

  // R11: extension register moves only on the rotate
  a_r11_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_we |=> $stable(ext_q));
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic [W-1:0]     operand,
  output logic [W-1:0]     acc_q,
  output logic [W-1:0]     ext_q,
  output logic             carry_q,
  output logic             zero_q,
  output logic             sign_q,
  output logic             irq_en_q
);
  logic [W-1:0] nxt_acc, nxt_ext, flag_src;
  logic         nxt_carry, nxt_ie;
  logic         acc_we, ext_we, carry_we, ie_we, flag_we, op_known;

  acc_alu #(.W(W)) u_alu (
    .op_valid (op_valid), .op_code (op_code), .operand (operand),
    .acc (acc_q), .ext (ext_q), .carry (carry_q),
    .nxt_acc (nxt_acc), .nxt_ext (nxt_ext), .nxt_carry (nxt_carry),
    .nxt_ie (nxt_ie), .flag_src (flag_src),
    .acc_we (acc_we), .ext_we (ext_we), .carry_we (carry_we),
    .ie_we (ie_we), .flag_we (flag_we), .op_known (op_known)
  );

  acc_regs #(.W(W)) u_regs (
    .clk (clk), .rst_n (rst_n),
    .nxt_acc (nxt_acc), .nxt_ext (nxt_ext), .nxt_carry (nxt_carry),
    .nxt_ie (nxt_ie), .flag_src (flag_src),
    .acc_we (acc_we), .ext_we (ext_we), .carry_we (carry_we),
    .ie_we (ie_we), .flag_we (flag_we),
    .acc_q (acc_q), .ext_q (ext_q), .carry_q (carry_q),
    .zero_q (zero_q), .sign_q (sign_q), .ie_q (irq_en_q)
  );

  // R12: idle cycles and unused codes change nothing
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || !op_known) |=> $stable(acc_q) && $stable(ext_q) && $stable(carry_q)
                                 && $stable(zero_q) && $stable(sign_q) && $stable(irq_en_q));

  // R10: compare and test keep the accumulator and carry
  a_r10_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_CMP || op_code == OP_TST)) |=> $stable(acc_q) && $stable(carry_q));

  // R4: clear-carry leaves carry low
  a_r4_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CCLR) |=> !carry_q);

  // R8: rotate moves accumulator bit 0 to the top of the extension
  a_r8_rot_link: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ROTX) |=> (ext_q[W-1] == $past(acc_q[0])) && (acc_q[W-1] == $past(ext_q[0])));

  // R7: arithmetic right shift keeps the sign bit
  a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ASR) |=> (acc_q[W-1] == $past(acc_q[W-1])));
endmodule

// File: tb/test_acc_exec_unit.sv
`timescale 1ns/1ps
module test_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [15:0] operand = '0;
  logic [15:0] acc_q, ext_q;
  logic        carry_q, zero_q, sign_q, irq_en_q;

  int vectors = 0;
  int fails = 0;

  logic [15:0] m_acc = 16'h0, m_ext = 16'h0;
  logic        m_c = 1'b0, m_z = 1'b1, m_s = 1'b0, m_ie = 1'b0;

  always #2.5 clk = ~clk;

  acc_exec_unit i_acc_exec_unit (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
    .operand (operand), .acc_q (acc_q), .ext_q (ext_q), .carry_q (carry_q),
    .zero_q (zero_q), .sign_q (sign_q), .irq_en_q (irq_en_q)
  );

  function automatic string req_of(input logic v, input logic [4:0] c);
    if (!v) return "R12";
    case (c)
      5'h00, 5'h01: return "R2";
      5'h02, 5'h03, 5'h04: return "R3";
      5'h05, 5'h06, 5'h07: return "R4";
      5'h08, 5'h09: return "R5";
      5'h0A, 5'h0B: return "R6";
      5'h0C: return "R7";
      5'h0D: return "R8";
      5'h0E, 5'h0F: return "R9";
      5'h10, 5'h11: return "R10";
      default: return "R12";
    endcase
  endfunction

  // bench model of R2..R12, written from the requirement text
  task automatic model(input logic v, input logic [4:0] c, input logic [15:0] b);
    logic [15:0] a;
    logic        wr;
    logic [16:0] wide;
    if (!v) return;
    a = m_acc; wr = 1'b1;
    case (c)
      5'h00: a = 16'h0000;
      5'h01: a = a ^ 16'hFFFF;
      5'h02: a = a & b;
      5'h03: a = a | b;
      5'h04: a = a ^ b;
      5'h05: begin m_c = 1'b0; wr = 1'b0; end
      5'h06: begin m_c = 1'b1; wr = 1'b0; end
      5'h07: begin m_c = !m_c; wr = 1'b0; end
      5'h08: begin m_ie = 1'b1; wr = 1'b0; end
      5'h09: begin m_ie = 1'b0; wr = 1'b0; end
      5'h0A: begin m_c = a[15]; a = a * 2; end
      5'h0B: begin m_c = a[0]; a = a / 2; end
      5'h0C: a = (a / 2) | (a & 16'h8000);
      5'h0D: begin
        logic lo_acc;
        lo_acc = a[0];
        a = (a / 2) | (m_ext[0] ? 16'h8000 : 16'h0);
        m_ext = (m_ext / 2) | (lo_acc ? 16'h8000 : 16'h0);
      end
      5'h0E: begin m_c = (a == 16'hFFFF); a = a + 16'd1; end
      5'h0F: begin m_c = (a == 16'h0000); a = a - 16'd1; end
      5'h10: begin
        wide = {1'b0, a} + {1'b0, ~b} + 17'd1;
        m_z = (wide[15:0] == 16'h0); m_s = wide[15]; wr = 1'b0;
      end
      5'h11: begin m_z = ((a & b) == 16'h0); m_s = a[15] & b[15]; wr = 1'b0; end
      default: wr = 1'b0;
    endcase
    if (wr && c <= 5'h0F) begin
      m_acc = a; m_z = (a == 16'h0); m_s = a[15];
    end
  endtask

  task automatic compare(input string rq);
    if ({acc_q, ext_q, carry_q, zero_q, sign_q, irq_en_q} !==
        {m_acc, m_ext, m_c, m_z, m_s, m_ie}) begin
      fails++;
      $display("FAIL %s: got acc=%h ext=%h c=%b z=%b s=%b ie=%b, expected acc=%h ext=%h c=%b z=%b s=%b ie=%b",
               rq, acc_q, ext_q, carry_q, zero_q, sign_q, irq_en_q,
               m_acc, m_ext, m_c, m_z, m_s, m_ie);
    end
  endtask

  task automatic apply(input logic v, input logic [4:0] c, input logic [15:0] b);
    @(negedge clk);
    op_valid = v; op_code = c; operand = b;
    @(posedge clk);
    #1;
    model(v, c, b);
    vectors++;
    compare(req_of(v, c));
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd7731);
    repeat (3) @(posedge clk);
    #1;
    vectors++; compare("R1");                // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    vectors++; compare("R1");                // R1 after release

    apply(1, 5'h03, 16'h8001);               // R3 OR loads
    apply(1, 5'h0C, 16'h0000);               // R7 ASR negative
    apply(1, 5'h0A, 16'h0000);               // R6 SHL carry out
    apply(1, 5'h0B, 16'h0000);               // R6 SHR
    apply(1, 5'h00, 16'h0000);               // R2 clear
    apply(1, 5'h0F, 16'h0000);               // R9 borrow at 0
    apply(1, 5'h0E, 16'h0000);               // R9 carry at FFFF
    apply(1, 5'h01, 16'h0000);               // R2 invert
    apply(1, 5'h0D, 16'h0000);               // R8 rotate
    apply(1, 5'h0D, 16'h0000);               // R8 rotate again
    apply(1, 5'h10, m_acc);                  // R10 compare equal
    apply(1, 5'h11, 16'h0000);               // R10 test zero
    apply(1, 5'h06, 16'h0000);               // R4 set carry
    apply(1, 5'h07, 16'h0000);               // R4 invert carry
    apply(1, 5'h08, 16'h0000);               // R5 enable
    apply(1, 5'h1F, 16'hFFFF);               // R12 unused code
    apply(0, 5'h00, 16'h0000);               // R12 idle clear
    apply(1, 5'h09, 16'h0000);               // R5 disable
    apply(1, 5'h04, 16'hA5A5);               // R3 xor, R11 flags

    for (int k = 0; k < 3000; k++) begin
      logic [4:0] c;
      logic       v;
      c = (($urandom % 4) == 0) ? 5'($urandom) : 5'($urandom % 18);
      v = (($urandom % 8) != 0);
      apply(v, c, 16'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule